// File: doc/BRIEF.md
# Iterative Floating-Point Normalizer

This block takes a binary floating-point value that may not be normalized and returns it in normal form. Both values use the same 16-bit word: a sign bit, a signed exponent and a fraction. The unit shifts the fraction left one place per clock and lowers the exponent by one for each shift. It stops as soon as the leading fraction bit is 1. The number that the word represents does not change.

Two inputs never reach the shift loop. A zero fraction becomes the canonical zero word at once. An input that is already normalized is passed straight through. Some shift sequences would carry the exponent below its most negative value. These end with the canonical zero word and an underflow flag.

A single-cycle start pulse begins an operation. A single-cycle done pulse returns the result, and `busy` covers the cycles spent shifting. Rounding, arithmetic between operands and any radix other than 2 are outside this block.

Top module: `fp_normalizer`

## Requirements
- R1: The word layout is bit 15 = sign, bits 14:9 = exponent in 6-bit two's complement (range -32..31), and bits 8:0 = fraction. The binary point sits just left of bit 8, so the value is (fraction/512) * 2^exponent. For a nonzero result, the output fraction equals the input fraction shifted left by (input exponent - output exponent).
- R2: If `inValid` is sampled in idle and bit 8 of the input fraction is 1, the next cycle shows `outValid` for one cycle. `outWord` equals the input word and both flags are 0.
- R3: An input with a nonzero fraction that has n leading zeros (n >= 1) takes n shift cycles. `outValid` rises n+1 cycles after the start edge. The result has bit 8 = 1, exponent = input exponent - n and fraction = input fraction << n. This applies when the exponent stays at or above -32.
- R4: If the input fraction is 0, `outValid` rises the cycle after start. `outWord` is all zeros, including a sign of 0. `zeroFlag` is 1 and `underflowFlag` is 0.
- R5: Let the input have e + 32 < n. After e + 32 shifts the exponent reaches -32 while bit 8 is still 0. `outValid` then rises e + 34 cycles after the start edge. `outWord` is all zeros, `underflowFlag` is 1 and `zeroFlag` is 0.
- R6: A start sampled while `busy` is 1 is ignored. The running result is unchanged and no extra result appears afterwards.
- R7: `busy` is 1 from the cycle after an accepted start that needs shifting until the result appears. `outValid` is a one-cycle pulse, and `busy` and `outValid` are never both 1.
- R8: After reset, `outValid`, `busy`, `zeroFlag` and `underflowFlag` are 0, and `outWord` is 0.
- R9: For a nonzero result, bit 15 of `outWord` equals bit 15 of the input word.
- R10: `outWord` and the flags keep their value after the `outValid` pulse until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Start strobe, one cycle |
| inWord | input | 16 | Value to normalize |
| busy | output | 1 | Shift loop running |
| outValid | output | 1 | Result strobe, one cycle |
| outWord | output | 16 | Normalized result |
| zeroFlag | output | 1 | Result came from a zero fraction |
| underflowFlag | output | 1 | Exponent ran out before normal form |

## Verification
The bench targets five corner cases:
- A fraction of 1 needs the longest run of eight shifts. A wrong loop bound ends early and leaves bit 8 clear.
- An exponent that lands exactly on -32 at the last shift must still give a normal result. An off-by-one underflow test reports underflow instead.
- An exponent of -32 with an unnormalized fraction must underflow after one cycle, with an all-zero word.
- A negative zero input must lose its sign. A design that passes the sign through shows bit 15 set.
- Starts injected while busy must neither corrupt the result nor leave a queued second result. A design that accepts them shows a changed word or a stray done pulse.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
  localparam int DEF_EXP_W  = 6;
  localparam int DEF_FRAC_W = 9;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;       // capture operand into working registers
    logic shift;      // one left shift, exponent minus one
    logic passIn;     // input already normal, publish as is
    logic doneShift;  // shifted value is normal, publish it
    logic doneZero;   // zero fraction, publish real zero
    logic doneUflow;  // exponent exhausted, publish real zero
  } nrmStrobe_t;

  typedef enum logic {ST_IDLE, ST_RUN} nrmState_t;
endpackage

// File: rtl/nrm_ctrl.sv
module nrm_ctrl
  import nrm_pkg::*;
#(
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inFracZero,
  input  logic       inFracMsb,
  input  logic       workExpMin,
  input  logic       shiftFracMsb,
  output nrmStrobe_t strb,
  output logic       busy
);
  localparam int CNT_W = $clog2(FRAC_W + 2);

  nrmState_t state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (inValid) begin
          if (inFracZero)     strb.doneZero = 1'b1;
          else if (inFracMsb) strb.passIn   = 1'b1;
          else begin
            strb.load = 1'b1;
            stateNext = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (workExpMin) begin
          strb.doneUflow = 1'b1;
          stateNext      = ST_IDLE;
        end else begin
          strb.shift = 1'b1;
          if (shiftFracMsb) begin
            strb.doneShift = 1'b1;
            stateNext      = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_RUN);

  // Cycle counter for the run-length check below
  logic [CNT_W-1:0] runCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
    else           runCnt <= '0;
  end

  // R3: a run never exceeds one cycle per fraction bit
  p_run_bounded_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runCnt < CNT_W'(FRAC_W)));

  // R6: while running, a start strobe never reloads the operand
  p_no_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && inValid) |=> !$past(strb.load));
endmodule

// File: rtl/nrm_datapath.sv
module nrm_datapath
  import nrm_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  nrmStrobe_t                   strb,
  input  logic [EXP_W+FRAC_W:0]        inWord,
  output logic                         inFracZero,
  output logic                         inFracMsb,
  output logic                         workExpMin,
  output logic                         shiftFracMsb,
  output logic                         outValid,
  output logic [EXP_W+FRAC_W:0]        outWord,
  output logic                         zeroFlag,
  output logic                         underflowFlag
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam logic signed [EXP_W-1:0] EXP_MIN = {1'b1, {(EXP_W-1){1'b0}}};

  logic                     workSign;
  logic signed [EXP_W-1:0]  workExp;
  logic [FRAC_W-1:0]        workFrac;
  logic [FRAC_W-1:0]        inFrac;
  logic [FRAC_W-1:0]        shiftFrac;
  logic signed [EXP_W-1:0]  shiftExp;

  assign inFrac       = inWord[FRAC_W-1:0];
  assign inFracZero   = (inFrac == '0);
  assign inFracMsb    = inFrac[FRAC_W-1];
  assign shiftFrac    = {workFrac[FRAC_W-2:0], 1'b0};
  assign shiftExp     = workExp - 1'b1;
  assign shiftFracMsb = shiftFrac[FRAC_W-1];
  assign workExpMin   = (workExp == EXP_MIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workSign <= 1'b0;
      workExp  <= '0;
      workFrac <= '0;
    end else if (strb.load) begin
      workSign <= inWord[WORD_W-1];
      workExp  <= inWord[WORD_W-2:FRAC_W];
      workFrac <= inFrac;
    end else if (strb.shift) begin
      workExp  <= shiftExp;
      workFrac <= shiftFrac;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      outWord       <= '0;
      zeroFlag      <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      outValid <= strb.passIn | strb.doneShift | strb.doneZero | strb.doneUflow;
      if (strb.passIn) begin
        outWord       <= inWord;
        zeroFlag      <= 1'b0;
        underflowFlag <= 1'b0;
      end else if (strb.doneShift) begin
        outWord       <= {workSign, shiftExp, shiftFrac};
        zeroFlag      <= 1'b0;
        underflowFlag <= 1'b0;
      end else if (strb.doneZero) begin
        outWord       <= '0;
        zeroFlag      <= 1'b1;
        underflowFlag <= 1'b0;
      end else if (strb.doneUflow) begin
        outWord       <= '0;
        zeroFlag      <= 1'b0;
        underflowFlag <= 1'b1;
      end
    end
  end

  // R3: a plain result is always in normal form
  p_norm_msb_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !zeroFlag && !underflowFlag) |-> outWord[FRAC_W-1]);

  // R4: a zero result is the all-zero word
  p_zero_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && zeroFlag) |-> (outWord == '0));

  // R5: an underflow result is the all-zero word
  p_uflow_word_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && underflowFlag) |-> (outWord == '0));

  // R9: the working sign never changes while shifting
  p_sign_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.shift) |-> (workSign == $past(workSign)));

  // R10: the result word only moves on a done pulse
  p_hold_word_r10: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outWord));
endmodule

// File: rtl/fp_normalizer.sv
module fp_normalizer #(
  parameter int EXP_W  = 6,
  parameter int FRAC_W = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] inWord,
  output logic                  busy,
  output logic                  outValid,
  output logic [EXP_W+FRAC_W:0] outWord,
  output logic                  zeroFlag,
  output logic                  underflowFlag
);
  import nrm_pkg::*;

  nrmStrobe_t strb;
  logic inFracZero, inFracMsb, workExpMin, shiftFracMsb;

  nrm_ctrl #(.FRAC_W(FRAC_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .inFracZero   (inFracZero),
    .inFracMsb    (inFracMsb),
    .workExpMin   (workExpMin),
    .shiftFracMsb (shiftFracMsb),
    .strb         (strb),
    .busy         (busy)
  );

  nrm_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .inWord        (inWord),
    .inFracZero    (inFracZero),
    .inFracMsb     (inFracMsb),
    .workExpMin    (workExpMin),
    .shiftFracMsb  (shiftFracMsb),
    .outValid      (outValid),
    .outWord       (outWord),
    .zeroFlag      (zeroFlag),
    .underflowFlag (underflowFlag)
  );

  // R7: busy and the done pulse never overlap
  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && outValid));

  // R7: a done pulse lasts exactly one cycle unless a fresh start arrived
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(inValid)) |-> !$past(outValid));
endmodule

// File: tb/sim_fp_normalizer.sv
module sim_fp_normalizer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inWord = '0;
  logic        busy, outValid, zeroFlag, underflowFlag;
  logic [15:0] outWord;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fp_normalizer u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .busy(busy), .outValid(outValid), .outWord(outWord),
    .zeroFlag(zeroFlag), .underflowFlag(underflowFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: latency counted in edges from the start edge
  task automatic model(input logic [15:0] w, output int lat, output logic [15:0] ow,
                       output bit z, output bit u);
    int frac = int'(w[8:0]);
    int e = int'($signed(w[14:9]));
    int n = 0;
    z = 0; u = 0;
    if (frac == 0) begin
      lat = 1; ow = 16'h0; z = 1;
    end else begin
      while (frac < 256) begin frac = frac * 2; n++; end
      if (n == 0) begin
        lat = 1; ow = w;
      end else if (n <= e + 32) begin
        lat = n + 1;
        ow = {w[15], 6'(e - n), 9'(frac)};
      end else begin
        lat = e + 34; ow = 16'h0; u = 1;
      end
    end
  endtask

  task automatic runOp(input logic [15:0] w, input bit inject, input logic [15:0] junk);
    int lat; logic [15:0] ow; bit z, u;
    model(w, lat, ow, z, u);
    @(negedge clk);
    inValid = 1'b1; inWord = w;
    for (int c = 1; c <= lat + 2; c++) begin
      @(negedge clk);
      inValid = 1'b0;
      if (inject && c == 1 && lat >= 2) begin
        inValid = 1'b1; inWord = junk;   // R6: start while busy
      end
      if (c <= lat) begin
        check(outValid == (c == lat), "R7 outValid timing", outValid, c == lat);
        check(busy == (c < lat), "R7 busy", busy, c < lat);
        if (c == lat) begin
          check(outWord == ow, z ? "R4 zero word" : (u ? "R5 underflow word" :
                (lat == 1 ? "R2 pass word" : "R3 shifted word")), outWord, ow);
          check(zeroFlag == z, "R4 zeroFlag", zeroFlag, z);
          check(underflowFlag == u, "R5 underflowFlag", underflowFlag, u);
          if (!z && !u) begin
            int fi = int'(w[8:0]);
            int ei = int'($signed(w[14:9]));
            int eo = int'($signed(outWord[14:9]));
            int fo = int'(outWord[8:0]);
            check((ei >= eo) && (fo == (fi << (ei - eo))), "R1 value kept", fo, fi);
            check(outWord[15] == w[15], "R9 sign", outWord[15], w[15]);
          end
        end
      end else begin
        check(!outValid, "R6/R10 no extra result", outValid, 0);
        check(outWord == ow, "R10 word held", outWord, ow);
        check(zeroFlag == z && underflowFlag == u, "R10 flags held",
              {zeroFlag, underflowFlag}, {z, u});
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && !busy && !zeroFlag && !underflowFlag && outWord == 0,
          "R8 reset", {outValid, busy, zeroFlag, underflowFlag}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !busy && outWord == 0, "R8 after release", outWord, 0);

    runOp(16'b0_000100_100111000, 0, 0);  // R2 already normal
    runOp(16'b0_000101_010011100, 0, 0);  // R3 one shift
    runOp(16'b1_000000_000000001, 0, 0);  // R3 longest run, negative sign R9
    runOp(16'b1_011111_000000000, 0, 0);  // R4 negative zero
    runOp(16'b0_101000_000000001, 0, 0);  // R3 lands exactly on -32
    runOp(16'b0_100010_000000001, 0, 0);  // R5 underflow mid-run
    runOp(16'b1_100000_001000000, 0, 0);  // R5 already at minimum
    runOp(16'b0_011111_000100000, 1, 16'b0_000001_100000000); // R6
    runOp(16'b0_100001_000000011, 1, 16'b0_000000_000000000); // R6 with R5
    begin
      logic [15:0] s = 16'hACE1;
      for (int i = 0; i < 40; i++) begin
        s = s ^ (s << 7); s = s ^ (s >> 9); s = s ^ (s << 8);
        runOp((i % 3 == 0) ? (s & 16'hFE3F) : s, i[0], ~s);
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule